// File: doc/BRIEF.md
# Tensor Context Issue Scheduler

This block sits in front of a shared tensor datapath and keeps up to eight independent tensor-operation contexts in flight. Each context is armed by a start pulse that carries an element count and a priority flag. In every cycle the scheduler looks at all armed contexts. It picks one whose input operands are present and whose output has room, and offers that context's identifier to the datapath. The offer can move to a different context on any cycle at no cost, so a context that stalls does not leave the datapath idle while another context could use it.

The issue interface is valid/ready. `issue_valid_o` and `issue_id_o` come from combinational logic driven by the current readiness inputs and the scheduler state. An issue completes only on a clock edge where both `issue_valid_o` and `issue_ready_i` are high. While the datapath holds `issue_ready_i` low, no count changes and no pointer moves. With unchanged inputs the same context stays on offer. Each completed issue consumes one element of the chosen context. The issue that uses the last element retires the context and produces a one-cycle done pulse on that context's bit. Context start, operand availability, output space and done are plain level or pulse signals.

Top module: `tensor_ctx_sched`

## Requirements
- R1: After reset no context is busy, `issue_valid_o` is low and `done_o` is all zero, even when every availability and space bit is high.
- R2: A `start_i` pulse with a nonzero `start_count_i` to an idle context makes `busy_o[start_id_i]` high on the next cycle. The context then holds that count and the given priority flag (`start_hi_i`=1 means high priority).
- R3: A start to a context that is already busy, or a start with a count of zero, is ignored: the busy state and the remaining count are unchanged.
- R4: A context is eligible only when it is busy, its `ctx_in_avail_i` bit is 1 and its `ctx_out_space_i` bit is 1. `issue_valid_o` is low exactly when no context is eligible.
- R5: When any high-priority context is eligible, the offered context is a high-priority one.
- R6: Within one priority level the search starts at that level's pointer and goes upward, wrapping past the last index. After an accepted issue, the pointer of the winner's level moves to the winner index plus one, modulo 8. Both pointers start at 0 after reset.
- R7: An issue takes effect only on a cycle where `issue_ready_i` is 1. While ready is low, counts and pointers hold, and with unchanged inputs `issue_id_o` stays the same.
- R8: Each accepted issue lowers the chosen context's count by one. The issue that brings the count to zero clears its busy bit and raises its `done_o` bit for exactly the one following cycle.
- R9: Accepted issues on consecutive cycles may come from different contexts, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one context |
| start_id_i | input | 3 | Context to start |
| start_count_i | input | 16 | Number of elements to issue |
| start_hi_i | input | 1 | Priority flag for the started context, 1 = high |
| ctx_in_avail_i | input | 8 | Per context: input operands present |
| ctx_out_space_i | input | 8 | Per context: output has space |
| issue_valid_o | output | 1 | An eligible context is on offer |
| issue_id_o | output | 3 | Identifier of the offered context |
| issue_ready_i | input | 1 | Datapath accepts the offer this cycle |
| busy_o | output | 8 | Per context: armed and not yet retired |
| done_o | output | 8 | Per context: one-cycle retire pulse |

## Verification
The embedded properties check on every cycle that an offered context really is busy, fed and unblocked, and that a high-priority context is chosen whenever one is eligible. They also check that a context's count is frozen on cycles with no accepted issue and no accepted start, and that done pulses appear only on the cycle after that context's busy bit falls. The actual round-robin order, the exact counts at which contexts retire, and the cases where a start is ignored are shown only by the bench's scenarios. Those scenarios compare the offered identifier and the busy and done bits against hand-derived sequences.

// File: rtl/tensor_sched_pkg.sv
package tensor_sched_pkg;

  typedef enum logic {
    PRI_LO = 1'b0,
    PRI_HI = 1'b1
  } pri_e;

  // Index that follows idx in a ring of n entries.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
  import tensor_sched_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_count_i,
  input  logic             start_hi_i,
  input  logic             take_i,
  output logic             busy_o,
  output pri_e             pri_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  pri_e             pri_q;
  logic             done_q;
  logic             start_ok;
  logic             last_take;

  assign start_ok  = start_i && !busy_q && (start_count_i != '0);
  assign last_take = take_i && busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      pri_q  <= PRI_LO;
      done_q <= 1'b0;
    end else begin
      done_q <= last_take;
      if (start_ok) begin
        cnt_q  <= start_count_i;
        busy_q <= 1'b1;
        pri_q  <= start_hi_i ? PRI_HI : PRI_LO;
      end else if (take_i && busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_take) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign pri_o  = pri_q;
  assign done_o = done_q;

  // R7/R3: without an accepted issue or start, the count holds
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !start_ok) |=> $stable(cnt_q));

  // R8: a done pulse follows the fall of busy
  p_done_after_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($fell(busy_q) && !busy_q));

  // R8: an issue is never taken by an idle slot
  p_take_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> busy_q);

endmodule

// File: rtl/rr_pick.sv
module rr_pick
  import tensor_sched_pkg::*;
#(
  parameter int N    = 8,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  input  logic [ID_W-1:0] ptr_i,
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);

  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    for (int off = 0; off < N; off++) begin
      int unsigned idx;
      idx = (int'(ptr_i) + off) % N;
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        id_o  = ID_W'(idx);
      end
    end
  end

endmodule

// File: rtl/tensor_ctx_sched.sv
module tensor_ctx_sched
  import tensor_sched_pkg::*;
#(
  parameter int NCTX  = 8,
  parameter int CNT_W = 16,
  localparam int ID_W = $clog2(NCTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ID_W-1:0]  start_id_i,
  input  logic [CNT_W-1:0] start_count_i,
  input  logic             start_hi_i,
  input  logic [NCTX-1:0]  ctx_in_avail_i,
  input  logic [NCTX-1:0]  ctx_out_space_i,
  output logic             issue_valid_o,
  output logic [ID_W-1:0]  issue_id_o,
  input  logic             issue_ready_i,
  output logic [NCTX-1:0]  busy_o,
  output logic [NCTX-1:0]  done_o
);

  logic [NCTX-1:0] busy;
  logic [NCTX-1:0] is_hi;
  logic [NCTX-1:0] elig;
  logic [NCTX-1:0] elig_hi;
  logic [NCTX-1:0] elig_lo;
  logic [NCTX-1:0] take;
  logic [ID_W-1:0] ptr_q [2];
  logic [ID_W-1:0] lvl_id [2];
  logic            lvl_any [2];
  logic            accept;

  for (genvar c = 0; c < NCTX; c++) begin : g_slot
    pri_e pri_c;
    ctx_slot #(.CNT_W(CNT_W)) i_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i && (start_id_i == ID_W'(c))),
      .start_count_i(start_count_i),
      .start_hi_i   (start_hi_i),
      .take_i       (take[c]),
      .busy_o       (busy[c]),
      .pri_o        (pri_c),
      .done_o       (done_o[c])
    );
    assign is_hi[c] = (pri_c == PRI_HI);
    assign take[c]  = accept && (issue_id_o == ID_W'(c));
  end

  assign elig    = busy & ctx_in_avail_i & ctx_out_space_i;
  assign elig_hi = elig & is_hi;
  assign elig_lo = elig & ~is_hi;

  for (genvar l = 0; l < 2; l++) begin : g_lvl
    rr_pick #(.N(NCTX), .ID_W(ID_W)) i_pick (
      .req_i(l == 1 ? elig_hi : elig_lo),
      .ptr_i(ptr_q[l]),
      .any_o(lvl_any[l]),
      .id_o (lvl_id[l])
    );
  end

  assign issue_valid_o = lvl_any[1] || lvl_any[0];
  assign issue_id_o    = lvl_any[1] ? lvl_id[1] : lvl_id[0];
  assign accept        = issue_valid_o && issue_ready_i;
  assign busy_o        = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q[0] <= '0;
      ptr_q[1] <= '0;
    end else if (accept) begin
      if (lvl_any[1]) ptr_q[1] <= ID_W'(ring_next(int'(issue_id_o), NCTX));
      else            ptr_q[0] <= ID_W'(ring_next(int'(issue_id_o), NCTX));
    end
  end

  // R4: an offered context is busy, fed and unblocked
  p_offer_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> (busy[issue_id_o] && ctx_in_avail_i[issue_id_o] && ctx_out_space_i[issue_id_o]));

  // R5: a high-priority context wins whenever one is eligible
  p_hi_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid_o && (elig_hi != '0)) |-> is_hi[issue_id_o]);

  // R7: pointers hold while no issue is accepted
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(ptr_q[0]) && $stable(ptr_q[1])));

  // R8: at most one context retires per cycle
  p_one_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));

  // R1: nothing is offered in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!issue_valid_o && (done_o == '0)));

endmodule

// File: tb/test_tensor_ctx_sched.sv
module test_tensor_ctx_sched;

  localparam int CLK_PER = 10;
  localparam int NV      = 14;

  typedef struct packed {
    logic [7:0] av;
    logic [7:0] sp;
    logic       rdy;
    logic       vld;
    logic [2:0] id;
  } vec_t;

  // Contexts 0..7 armed with 50 elements, 5 and 6 high priority, pointers at 0
  localparam vec_t VEC [NV] = '{
    '{8'hFF, 8'h00, 1'b1, 1'b0, 3'd0},  // R4 no output space
    '{8'h00, 8'hFF, 1'b1, 1'b0, 3'd0},  // R4 no input data
    '{8'h0F, 8'h0F, 1'b1, 1'b1, 3'd0},  // R6 lo ptr 0
    '{8'h0F, 8'h0F, 1'b1, 1'b1, 3'd1},  // R9 switch
    '{8'hFF, 8'hFF, 1'b1, 1'b1, 3'd5},  // R5 hi first
    '{8'hFF, 8'hFF, 1'b1, 1'b1, 3'd6},  // R6 hi rotate
    '{8'hFF, 8'hFF, 1'b1, 1'b1, 3'd5},  // R6 hi wrap
    '{8'hFF, 8'hFF, 1'b0, 1'b1, 3'd6},  // R7 stall
    '{8'hFF, 8'hFF, 1'b0, 1'b1, 3'd6},  // R7 stall held
    '{8'h9F, 8'hFF, 1'b1, 1'b1, 3'd2},  // R6 lo resumes at 2
    '{8'h90, 8'hFF, 1'b1, 1'b1, 3'd4},
    '{8'h90, 8'hFF, 1'b1, 1'b1, 3'd7},
    '{8'h90, 8'hFF, 1'b1, 1'b1, 3'd4},  // R6 lo wrap
    '{8'h01, 8'h01, 1'b1, 1'b1, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  start_id_i;
  logic [15:0] start_count_i;
  logic        start_hi_i;
  logic [7:0]  ctx_in_avail_i;
  logic [7:0]  ctx_out_space_i;
  logic        issue_valid_o;
  logic [2:0]  issue_id_o;
  logic        issue_ready_i;
  logic [7:0]  busy_o;
  logic [7:0]  done_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  tensor_ctx_sched i_tensor_ctx_sched (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .start_id_i(start_id_i),
    .start_count_i(start_count_i), .start_hi_i(start_hi_i),
    .ctx_in_avail_i(ctx_in_avail_i), .ctx_out_space_i(ctx_out_space_i),
    .issue_valid_o(issue_valid_o), .issue_id_o(issue_id_o),
    .issue_ready_i(issue_ready_i), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start_i = 1'b0; start_id_i = '0; start_count_i = '0; start_hi_i = 1'b0;
    ctx_in_avail_i = '0; ctx_out_space_i = '0; issue_ready_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic start_ctx(input int id, input int cnt, input logic hi);
    start_i = 1'b1; start_id_i = 3'(id); start_count_i = 16'(cnt); start_hi_i = hi;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: idle after reset even with everything ready
    ctx_in_avail_i = 8'hFF; ctx_out_space_i = 8'hFF; issue_ready_i = 1'b1;
    #1;
    check(!issue_valid_o, "R1 valid", int'(issue_valid_o), 0);
    check(busy_o == 8'h00, "R1 busy", int'(busy_o), 0);
    check(done_o == 8'h00, "R1 done", int'(done_o), 0);
    ctx_in_avail_i = '0; ctx_out_space_i = '0; issue_ready_i = 1'b0;

    // R2: arm all contexts
    for (int c = 0; c < 8; c++) start_ctx(c, 50, (c == 5 || c == 6));
    check(busy_o == 8'hFF, "R2 busy", int'(busy_o), 8'hFF);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      ctx_in_avail_i  = VEC[v].av;
      ctx_out_space_i = VEC[v].sp;
      issue_ready_i   = VEC[v].rdy;
      #1;
      check(issue_valid_o == VEC[v].vld, $sformatf("R4 vec%0d valid", v), int'(issue_valid_o), int'(VEC[v].vld));
      if (VEC[v].vld)
        check(issue_id_o == VEC[v].id, $sformatf("R6 vec%0d id", v), int'(issue_id_o), int'(VEC[v].id));
      @(negedge clk);
    end

    // R8: retire after exact count, one-cycle done
    do_reset();
    start_ctx(3, 2, 1'b0);
    ctx_in_avail_i = 8'h08; ctx_out_space_i = 8'h08; issue_ready_i = 1'b1;
    @(negedge clk);
    check(busy_o[3] && !done_o[3], "R8 mid count", int'(busy_o), 8'h08);
    @(negedge clk);
    check(!busy_o[3], "R8 retired", int'(busy_o), 0);
    check(done_o == 8'h08, "R8 done pulse", int'(done_o), 8'h08);
    check(!issue_valid_o, "R4 retired not offered", int'(issue_valid_o), 0);
    @(negedge clk);
    check(done_o == 8'h00, "R8 done one cycle", int'(done_o), 0);

    // R3: restart of busy context ignored
    ctx_in_avail_i = '0; ctx_out_space_i = '0;
    start_ctx(2, 3, 1'b0);
    start_ctx(2, 1, 1'b0);
    ctx_in_avail_i = 8'h04; ctx_out_space_i = 8'h04;
    @(negedge clk);
    check(busy_o[2], "R3 busy restart ignored", int'(busy_o), 8'h04);
    @(negedge clk);
    @(negedge clk);
    check(!busy_o[2] && done_o[2], "R3 original count kept", int'(done_o), 8'h04);

    // R3: zero-count start ignored
    start_ctx(1, 0, 1'b1);
    check(!busy_o[1], "R3 zero count", int'(busy_o), 0);

    // R7: stall keeps count; R9 back-to-back different contexts
    ctx_in_avail_i = '0; ctx_out_space_i = '0; issue_ready_i = 1'b0;
    start_ctx(4, 1, 1'b0);
    start_ctx(6, 1, 1'b0);
    ctx_in_avail_i = 8'h50; ctx_out_space_i = 8'h50;
    @(negedge clk);
    @(negedge clk);
    check(busy_o == 8'h50, "R7 stall holds", int'(busy_o), 8'h50);
    issue_ready_i = 1'b1;
    #1;
    check(issue_id_o == 3'd4, "R9 first", int'(issue_id_o), 4);
    @(negedge clk);
    check(issue_valid_o && issue_id_o == 3'd6, "R9 next cycle", int'(issue_id_o), 6);
    @(negedge clk);
    check(busy_o == 8'h00, "R9 both retired", int'(busy_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule